// File: doc/BRIEF.md
# Capture Command and Trigger Controller

This block sits between a character link and a packet capture engine. Each byte that arrives on a valid/ready command stream is read as a one-character command. The block keeps the settings that the capture engine needs: four packet-class filter enables (token, start-of-frame, data, setup), a 4-bit capture-length setting, and a run/stop state. It also keeps the last command byte so that a display can show it.

The capture engine pulses `line_done` once for each unfiltered packet that ends. While capture runs and the length setting N is not zero, the block counts those pulses. It stops capture when the count reaches N×32. A setting of zero means continuous capture with no limit. A rearm command starts a new single-shot window. The space command mutes all enabled filters as a group, and a second space brings back exactly the set that was muted.

The capture state machine has two states. `CAP_RUN` drives `cap_en` high and counts lines. `CAP_STOP` drives `cap_en` low and ignores lines. There are two transitions. The limit-reached transition goes from `CAP_RUN` to `CAP_STOP` on the line event that brings the count to the limit. The rearm transition goes from `CAP_STOP` to `CAP_RUN` on the rearm command. A rearm in `CAP_RUN` stays in `CAP_RUN` and clears the count.

Top module: `capcmd_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `filt_en` is 0, `len_set` is 0, `cap_en` is 1, `last_cmd` is 0x00 and `cmd_ready` is 1.
- R2: The bytes 0x31, 0x32, 0x33 and 0x34 invert `filt_en` bits 0 (token), 1 (start-of-frame), 2 (data) and 3 (setup). The output changes in the cycle after the byte is accepted.
- R3: When any filter is enabled, byte 0x20 (space) drives `filt_en` to 0 and remembers the enabled set. The next 0x20 restores that set. A filter byte sent while muted changes the remembered set, and `filt_en` stays 0. A space sent while no filter is enabled and none is muted has no effect.
- R4: Byte 0x37 raises `len_set` by one, and 15 wraps to 0.
- R5: Byte 0x38 lowers `len_set` by one, and 0 wraps to 15.
- R6: When `len_set` = N is not zero and `cap_en` is high, every cycle with `line_done` high counts one line. `cap_en` falls in the cycle after the line that brings the count to N×32.
- R7: When `len_set` is 0, `cap_en` never falls and the count is held at zero. After a change from 0 to N, the window is a full N×32 lines.
- R8: Byte 0x36 clears the line count and drives `cap_en` high in the next cycle. If it arrives in the same cycle as `line_done`, the rearm wins and that line is not counted.
- R9: While `cap_en` is low, `line_done` pulses are not counted. After a rearm, a full N×32 lines are needed to stop again.
- R10: `cmd_ready` is always high. Every accepted byte appears on `last_cmd` in the next cycle. Bytes not listed in R2 to R8 have no other effect.
- R11: Once capture has stopped, only byte 0x36 restarts it. Length changes leave `cap_en` low.
- R12: If the setting is lowered below the current count, capture keeps running and stops on the next counted line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte valid |
| cmd_data | input | 8 | Command byte |
| cmd_ready | output | 1 | Command byte accepted (always high) |
| line_done | input | 1 | One-cycle pulse per captured packet end |
| filt_en | output | 4 | Filter enables: bit0 token, bit1 start-of-frame, bit2 data, bit3 setup |
| cap_en | output | 1 | Capture enable |
| len_set | output | 4 | Length setting, in steps of 32 lines (0 = continuous) |
| last_cmd | output | 8 | Last accepted command byte |

## Verification
A table of command bytes exercises each filter toggle, the group mute and restore, length wrapping in both directions, and bytes with no command meaning. The table separates a mute flag that keeps the remembered set from one that loses it. It also checks that a toggle sent while muted reaches the remembered set and not the outputs. Line-count runs then count exactly N×32−1 and N×32 events, which exposes off-by-one limits. Further runs check that lines are ignored while stopped, that a rearm in the same cycle as a line wins, that the count is held in continuous mode, and that lowering the limit below the count stops capture on the next line.

// File: rtl/capcmd_pkg.sv
package capcmd_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] CH_SPACE = 8'h20;
    localparam logic [CMD_W-1:0] CH_FILT0 = 8'h31;
    localparam logic [CMD_W-1:0] CH_REARM = 8'h36;
    localparam logic [CMD_W-1:0] CH_INC   = 8'h37;
    localparam logic [CMD_W-1:0] CH_DEC   = 8'h38;

    typedef enum logic {
        CAP_RUN  = 1'b0,
        CAP_STOP = 1'b1
    } cap_state_e;

    typedef struct packed {
        logic grp;
        logic rearm;
        logic inc;
        logic dec;
    } cmd_ctl_t;

endpackage

// File: rtl/capcmd_decode.sv
module capcmd_decode
    import capcmd_pkg::*;
#(
    parameter int FILT_N = 4
) (
    input  logic             valid_i,
    input  logic [CMD_W-1:0] data_i,
    output logic [FILT_N-1:0] tog_o,
    output cmd_ctl_t         ctl_o
);

    for (genvar i = 0; i < FILT_N; i++) begin : g_tog
        assign tog_o[i] = valid_i && (data_i == CH_FILT0 + CMD_W'(i));
    end

    always_comb begin
        ctl_o       = '0;
        ctl_o.grp   = valid_i && (data_i == CH_SPACE);
        ctl_o.rearm = valid_i && (data_i == CH_REARM);
        ctl_o.inc   = valid_i && (data_i == CH_INC);
        ctl_o.dec   = valid_i && (data_i == CH_DEC);
    end

endmodule

// File: rtl/capcmd_filters.sv
module capcmd_filters #(
    parameter int FILT_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILT_N-1:0] tog_i,
    input  logic              grp_i,
    output logic [FILT_N-1:0] filt_en_o
);

    logic [FILT_N-1:0] sel_q;
    logic              mute_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            mute_q <= 1'b0;
        end else begin
            sel_q <= sel_q ^ tog_i;
            if (grp_i) begin
                if (mute_q)
                    mute_q <= 1'b0;
                else if (sel_q != '0)
                    mute_q <= 1'b1;
            end
        end
    end

    assign filt_en_o = mute_q ? '0 : sel_q;

    assert_mute_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grp_i && (filt_en_o != '0) |=> (filt_en_o == '0));

    assert_restore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grp_i && mute_q |=> (filt_en_o == $past(sel_q ^ tog_i)));

    assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_i && !mute_q |=> (filt_en_o == ($past(filt_en_o) ^ $past(tog_i))));

endmodule

// File: rtl/capcmd_limit.sv
module capcmd_limit
    import capcmd_pkg::*;
#(
    parameter int LEN_W     = 4,
    parameter int LINE_STEP = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    input  logic             rearm_i,
    input  logic             line_i,
    output logic [LEN_W-1:0] len_o,
    output logic             cap_en_o
);

    localparam int SH    = $clog2(LINE_STEP);
    localparam int CNT_W = LEN_W + SH;

    cap_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [LEN_W-1:0] len_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_inc;

    assign limit   = CNT_W'(len_q) << SH;
    assign cnt_inc = cnt_q + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            len_q <= '0;
        else if (inc_i)
            len_q <= len_q + LEN_W'(1);
        else if (dec_i)
            len_q <= len_q - LEN_W'(1);
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CAP_RUN: begin
                if (rearm_i || (len_q == '0)) begin
                    cnt_d = '0;
                end else if (line_i) begin
                    cnt_d = cnt_inc;
                    if (cnt_inc >= limit)
                        state_d = CAP_STOP;
                end
            end
            CAP_STOP: begin
                if (rearm_i) begin
                    state_d = CAP_RUN;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = CAP_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        cap_en_o = (state_q == CAP_RUN);
        len_o    = len_q;
    end

    assert_len_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> (len_o == $past(len_o) + LEN_W'(1)));

    assert_len_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i && !inc_i |=> (len_o == $past(len_o) - LEN_W'(1)));

    assert_stay_stopped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en_o && !rearm_i |=> !cap_en_o);

    assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> cap_en_o);

    assert_continuous_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en_o && (len_o == '0) |=> cap_en_o);

    assert_no_count_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en_o && !rearm_i |=> $stable(cnt_q));

endmodule

// File: rtl/capcmd_ctrl.sv
module capcmd_ctrl
    import capcmd_pkg::*;
#(
    parameter int FILT_N    = 4,
    parameter int LEN_W     = 4,
    parameter int LINE_STEP = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_data,
    output logic              cmd_ready,
    input  logic              line_done,
    output logic [FILT_N-1:0] filt_en,
    output logic              cap_en,
    output logic [LEN_W-1:0]  len_set,
    output logic [CMD_W-1:0]  last_cmd
);

    logic [FILT_N-1:0] tog;
    cmd_ctl_t          ctl;

    assign cmd_ready = 1'b1;

    capcmd_decode #(.FILT_N(FILT_N)) u_decode (
        .valid_i (cmd_valid),
        .data_i  (cmd_data),
        .tog_o   (tog),
        .ctl_o   (ctl)
    );

    capcmd_filters #(.FILT_N(FILT_N)) u_filters (
        .clk       (clk),
        .rst_n     (rst_n),
        .tog_i     (tog),
        .grp_i     (ctl.grp),
        .filt_en_o (filt_en)
    );

    capcmd_limit #(.LEN_W(LEN_W), .LINE_STEP(LINE_STEP)) u_limit (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (ctl.inc),
        .dec_i    (ctl.dec),
        .rearm_i  (ctl.rearm),
        .line_i   (line_done),
        .len_o    (len_set),
        .cap_en_o (cap_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            last_cmd <= '0;
        else if (cmd_valid)
            last_cmd <= cmd_data;
    end

    assert_last_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (last_cmd == $past(cmd_data)));

    assert_hold_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(last_cmd));

endmodule

// File: tb/capcmd_ctrl_tb.sv
module capcmd_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic       cmd_ready;
    logic       line_done = 1'b0;
    logic [3:0] filt_en;
    logic       cap_en;
    logic [3:0] len_set;
    logic [7:0] last_cmd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    capcmd_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .cmd_ready (cmd_ready),
        .line_done (line_done),
        .filt_en   (filt_en),
        .cap_en    (cap_en),
        .len_set   (len_set),
        .last_cmd  (last_cmd)
    );

    // {cmd[16:9], exp filt_en[8:5], exp len_set[4:1], exp cap_en[0]}
    localparam logic [16:0] VEC [16] = '{
        {8'h31, 4'b0001, 4'd0,  1'b1},  // R2 token on
        {8'h33, 4'b0101, 4'd0,  1'b1},  // R2 data on
        {8'h20, 4'b0000, 4'd0,  1'b1},  // R3 mute
        {8'h32, 4'b0000, 4'd0,  1'b1},  // R3 toggle while muted
        {8'h20, 4'b0111, 4'd0,  1'b1},  // R3 restore
        {8'h31, 4'b0110, 4'd0,  1'b1},  // R2 token off
        {8'h34, 4'b1110, 4'd0,  1'b1},  // R2 setup on
        {8'h41, 4'b1110, 4'd0,  1'b1},  // R10 no effect
        {8'h38, 4'b1110, 4'd15, 1'b1},  // R5 wrap 0->15
        {8'h38, 4'b1110, 4'd14, 1'b1},  // R5
        {8'h37, 4'b1110, 4'd15, 1'b1},  // R4
        {8'h37, 4'b1110, 4'd0,  1'b1},  // R4 wrap 15->0
        {8'h37, 4'b1110, 4'd1,  1'b1},  // R4
        {8'h35, 4'b1110, 4'd1,  1'b1},  // R10 no effect
        {8'h20, 4'b0000, 4'd1,  1'b1},  // R3 mute
        {8'h20, 4'b1110, 4'd1,  1'b1}   // R3 restore
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic lines(input int n);
        @(negedge clk);
        line_done = 1'b1;
        repeat (n) @(negedge clk);
        line_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 filt_en in reset", int'(filt_en), 0);
        check("R1 cap_en in reset", int'(cap_en), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 len_set", int'(len_set), 0);
        check("R1 last_cmd", int'(last_cmd), 0);
        check("R1 cmd_ready", int'(cmd_ready), 1);
        check("R1 cap_en", int'(cap_en), 1);

        for (int k = 0; k < 16; k++) begin
            send(VEC[k][16:9]);
            check($sformatf("R2/R3 filt_en vec %0d", k), int'(filt_en), int'(VEC[k][8:5]));
            check($sformatf("R4/R5 len_set vec %0d", k), int'(len_set), int'(VEC[k][4:1]));
            check($sformatf("R10 last_cmd vec %0d", k), int'(last_cmd), int'(VEC[k][16:9]));
            check($sformatf("R10 cap_en vec %0d", k), int'(cap_en), int'(VEC[k][0]));
            check("R10 cmd_ready", int'(cmd_ready), 1);
        end

        // R6: len 1 -> 32 lines
        lines(31);
        check("R6 running after 31 lines", int'(cap_en), 1);
        lines(1);
        check("R6 stopped after 32 lines", int'(cap_en), 0);

        // R9: lines while stopped ignored
        lines(5);
        check("R9 still stopped", int'(cap_en), 0);
        send(8'h36);
        check("R8 rearm", int'(cap_en), 1);
        lines(31);
        check("R9 full window after rearm", int'(cap_en), 1);
        lines(1);
        check("R9 stop after full window", int'(cap_en), 0);

        // R8: rearm together with a line
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = 8'h36;
        line_done = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        line_done = 1'b0;
        check("R8 rearm with line", int'(cap_en), 1);
        lines(31);
        check("R8 line in rearm cycle not counted", int'(cap_en), 1);
        lines(1);
        check("R8 stop", int'(cap_en), 0);

        // R11: length change does not restart
        send(8'h37);
        check("R11 len 2", int'(len_set), 2);
        check("R11 stays stopped", int'(cap_en), 0);

        // R12: lower limit below count
        send(8'h36);
        lines(40);
        check("R12 running at 40 of 64", int'(cap_en), 1);
        send(8'h38);
        check("R12 still running after lowering", int'(cap_en), 1);
        lines(1);
        check("R12 stop on next line", int'(cap_en), 0);

        // R7: continuous mode
        send(8'h38);
        check("R7 len 0", int'(len_set), 0);
        check("R11 stopped after len change", int'(cap_en), 0);
        send(8'h36);
        lines(600);
        check("R7 continuous after 600 lines", int'(cap_en), 1);
        send(8'h37);
        lines(31);
        check("R7 fresh window after leaving continuous", int'(cap_en), 1);
        lines(1);
        check("R7 stop after fresh window", int'(cap_en), 0);

        // R3: space with nothing enabled
        send(8'h32);  // 1110 -> 1100
        send(8'h33);  // -> 1000
        send(8'h34);  // -> 0000
        check("R2 all off", int'(filt_en), 0);
        send(8'h20);
        check("R3 space with none enabled", int'(filt_en), 0);
        send(8'h31);
        check("R3 space with none enabled had no effect", int'(filt_en), 1);

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 filt_en after reset", int'(filt_en), 0);
        check("R1 len_set after reset", int'(len_set), 0);
        check("R1 cap_en after reset", int'(cap_en), 1);
        check("R1 last_cmd after reset", int'(last_cmd), 0);

        finish_run();
    end

endmodule